// File: doc/BRIEF.md
# PHY Configuration Register Write Bridge

This block turns writes to one 32-bit host control word into single write transfers on a small bank of 8-bit PHY configuration registers. Software places a 6-bit register index and an 8-bit value into the control word and sets a request bit. The bridge captures index and value on the rising edge of the request and issues one write strobe toward the PHY. It then waits for the PHY's ready response, which may arrive any number of cycles later, and raises an acknowledge bit in the same control word.

The exchange is a full four-phase handshake. Software drops the request once it sees the acknowledge. The bridge then lowers the acknowledge, and only after that may the next request begin. A request raised while the acknowledge is still high breaks the protocol. The bridge refuses such a request and records it in a sticky error bit. Software clears that bit by writing a one to it.

The reset input is asynchronous and active low. Inside the block it is released synchronously, two clock edges after the input rises.

Top module: `phy_wr_bridge`

## Requirements
- R1: The control word reads back the register index at bits [5:0], the write value at bits [15:8], the request at bit 24, the acknowledge at bit 26 and the error flag at bit 31. Every other bit reads as 0, and writes to those bits have no effect.
- R2: A host write that takes bit 24 from 0 to 1 while the bridge is idle starts a transfer. In the next cycle, `phy_wr_stb` is high for exactly one cycle and carries the index and value that arrived with that write.
- R3: `phy_ready` counts only while the bridge waits after a strobe. A ready pulse at any other time has no effect on the acknowledge.
- R4: The acknowledge (bit 26) reads 1 from the cycle after the edge that samples `phy_ready`, so it reads 1 L+1 cycles after the strobe cycle when ready comes L cycles after the strobe, for any L from 1 to 8.
- R5: The acknowledge stays at 1 until the request has been seen low. It reads 0 from the second edge after the edge that wrote the request to 0.
- R6: Host writes that change the index or value fields while a transfer is in progress leave the PHY address and data of that transfer unchanged. The new field values still read back.
- R7: A write that raises the request while the acknowledge reads 1 sets bit 31 and starts no transfer. A request that rises while the bridge is busy and the acknowledge is low also starts nothing.
- R8: Writing 1 to bit 31 clears the error flag. If the same write also raises a request while the acknowledge is 1, the flag ends up set.
- R9: The acknowledge is read-only: writing bit 26 never changes it.
- R10: While reset is asserted the whole control word reads 0 and no strobe is issued, even when reset arrives in the middle of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Write enable for the control word |
| host_wdata | input | 32 | Value written to the control word |
| host_rdata | output | 32 | Current control word contents |
| phy_wr_stb | output | 1 | One-cycle PHY write strobe |
| phy_addr | output | 6 | PHY register index of the current transfer |
| phy_wdata | output | 8 | PHY write value of the current transfer |
| phy_ready | input | 1 | PHY write completion |

## Verification
Two events can fall on the same edge: a host write can both clear the sticky error flag and raise a request while the acknowledge is still high, which sets the flag again. The bench provokes this by dropping the request and raising it again in the very next write, with bit 31 also set in that write. The expected result is that the flag is set and no strobe appears. A second collision comes from a request that rises on the edge where the acknowledge is being released. The per-cycle reference model decides the expected word for every cycle, and explicit checks look at bit 31 and the strobe afterwards.

// File: rtl/phy_wr_pkg.sv
package phy_wr_pkg;
  localparam int REG_W    = 32;
  localparam int DATA_LSB = 8;
  localparam int REQ_BIT  = 24;
  localparam int ACK_BIT  = 26;
  localparam int ERR_BIT  = 31;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WRITING   = 2'd1,
    ST_ACK_HIGH  = 2'd2,
    ST_ACK_CLEAR = 2'd3
  } hs_state_e;
endpackage

// File: rtl/phy_wr_rst_sync.sv
module phy_wr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/phy_wr_hostreg.sv
module phy_wr_hostreg
  import phy_wr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wdata,
  input  logic              ack,
  input  logic              idle,
  output logic [REG_W-1:0]  rdata,
  output logic              start,
  output logic              req,
  output logic [ADDR_W-1:0] fld_addr,
  output logic [DATA_W-1:0] fld_data
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              req_q, req_d;
  logic              err_q, err_d;
  logic              rise, err_set, err_clr;
  logic              unused_wbits;

  assign unused_wbits = ^wdata;

  always_comb begin
    rise    = wr_en & wdata[REQ_BIT] & ~req_q;
    start   = rise & idle;
    err_set = rise & ack;
    err_clr = wr_en & wdata[ERR_BIT];

    addr_d = addr_q;
    data_d = data_q;
    req_d  = req_q;
    if (wr_en) begin
      addr_d = wdata[ADDR_W-1:0];
      data_d = wdata[DATA_LSB +: DATA_W];
      req_d  = wdata[REQ_BIT];
    end

    err_d = err_q;
    if (err_clr) err_d = 1'b0;
    if (err_set) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      req_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      data_q <= data_d;
      req_q  <= req_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    rdata                       = '0;
    rdata[ADDR_W-1:0]           = addr_q;
    rdata[DATA_LSB +: DATA_W]   = data_q;
    rdata[REQ_BIT]              = req_q;
    rdata[ACK_BIT]              = ack;
    rdata[ERR_BIT]              = err_q;
  end

  assign req      = req_q;
  assign fld_addr = wdata[ADDR_W-1:0];
  assign fld_data = wdata[DATA_LSB +: DATA_W];
endmodule

// File: rtl/phy_wr_fsm.sv
module phy_wr_fsm
  import phy_wr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic req,
  input  logic stb,
  input  logic ready,
  output logic ack,
  output logic idle
);
  hs_state_e state_q, state_d;
  logic      ack_q, ack_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (start)          state_d = ST_WRITING;
      ST_WRITING:   if (ready && !stb)  state_d = ST_ACK_HIGH;
      ST_ACK_HIGH:  if (!req)           state_d = ST_ACK_CLEAR;
      ST_ACK_CLEAR:                     state_d = ST_IDLE;
      default:                          state_d = ST_IDLE;
    endcase
    ack_d = (state_d == ST_ACK_HIGH) || (state_d == ST_ACK_CLEAR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
    end
  end

  assign ack  = ack_q;
  assign idle = (state_q == ST_IDLE);
endmodule

// File: rtl/phy_wr_port.sv
module phy_wr_port #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              stb,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  logic              stb_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (start) begin
      addr_q <= addr_in;
      data_q <= data_in;
    end
  end

  assign stb  = stb_q;
  assign addr = addr_q;
  assign data = data_q;
endmodule

// File: rtl/phy_wr_bridge.sv
module phy_wr_bridge
  import phy_wr_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [REG_W-1:0]  host_wdata,
  output logic [REG_W-1:0]  host_rdata,
  output logic              phy_wr_stb,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [DATA_W-1:0] phy_wdata,
  input  logic              phy_ready
);
  logic              rst_n_int;
  logic              start, req, ack, idle;
  logic [ADDR_W-1:0] fld_addr;
  logic [DATA_W-1:0] fld_data;

  phy_wr_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk        (clk),
    .rst_n_async(rst_n),
    .rst_n_sync (rst_n_int)
  );

  phy_wr_hostreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (host_wr_en),
    .wdata   (host_wdata),
    .ack     (ack),
    .idle    (idle),
    .rdata   (host_rdata),
    .start   (start),
    .req     (req),
    .fld_addr(fld_addr),
    .fld_data(fld_data)
  );

  phy_wr_fsm u_fsm (
    .clk  (clk),
    .rst_n(rst_n_int),
    .start(start),
    .req  (req),
    .stb  (phy_wr_stb),
    .ready(phy_ready),
    .ack  (ack),
    .idle (idle)
  );

  phy_wr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .start  (start),
    .addr_in(fld_addr),
    .data_in(fld_data),
    .stb    (phy_wr_stb),
    .addr   (phy_addr),
    .data   (phy_wdata)
  );
endmodule

// File: rtl/phy_wr_bridge_chk.sv
module phy_wr_bridge_chk
  import phy_wr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] host_rdata,
  input logic             phy_wr_stb,
  input logic             phy_ready
);
  logic [REG_W-1:0] live_mask;
  always_comb begin
    live_mask                     = '0;
    live_mask[ADDR_W-1:0]         = '1;
    live_mask[DATA_LSB +: DATA_W] = '1;
    live_mask[REQ_BIT]            = 1'b1;
    live_mask[ACK_BIT]            = 1'b1;
    live_mask[ERR_BIT]            = 1'b1;
  end

  a_r1_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rdata & ~live_mask) == '0);

  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    phy_wr_stb |=> !phy_wr_stb);

  a_r7_strobe_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
    phy_wr_stb |-> !host_rdata[ACK_BIT]);

  a_r4_ack_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_rdata[ACK_BIT]) |-> $past(phy_ready));

  a_r5_ack_drop_after_req_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_rdata[ACK_BIT]) |-> !$past(host_rdata[REQ_BIT], 2));

  a_r7_err_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_rdata[ERR_BIT]) |-> $past(host_rdata[ACK_BIT]));
endmodule

bind phy_wr_bridge phy_wr_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_rdata(host_rdata),
  .phy_wr_stb(phy_wr_stb),
  .phy_ready (phy_ready)
);

// File: tb/phy_wr_bridge_tb.sv
module phy_wr_bridge_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        host_wr_en;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic        phy_wr_stb;
  logic [5:0]  phy_addr;
  logic [7:0]  phy_wdata;
  logic        phy_ready;

  phy_wr_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .phy_wr_stb(phy_wr_stb), .phy_addr(phy_addr),
    .phy_wdata(phy_wdata), .phy_ready(phy_ready)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk(bit err, bit ack, bit req, logic [7:0] d, logic [5:0] a);
    return {err, 4'b0, ack, 1'b0, req, 8'b0, d, 2'b0, a};
  endfunction

  // PHY register bank with variable ready latency
  logic [7:0] phy_mem [64];
  int  phy_lat = 1;
  bit  spur    = 0;
  int  rdy_cnt = 0;

  initial begin
    for (int i = 0; i < 64; i++) phy_mem[i] = 8'h00;
    phy_ready = 1'b0;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      rdy_cnt   = 0;
      phy_ready = 1'b0;
    end else begin
      if (rdy_cnt > 0) begin
        rdy_cnt--;
        phy_ready = (rdy_cnt == 0);
      end else begin
        phy_ready = spur;
      end
      if (phy_wr_stb) begin
        phy_mem[phy_addr] = phy_wdata;
        rdy_cnt = phy_lat;
      end
    end
  end

  // Behavioural reference: phase 0 idle, 1 strobe, 2 waiting, 3 ack held, 4 ack releasing
  int         m_phase;
  bit         m_req, m_err, m_ack;
  logic [5:0] m_addr, m_laddr;
  logic [7:0] m_data, m_ldata;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_req = 0; m_err = 0; m_ack = 0;
      m_addr = 0; m_data = 0; m_laddr = 0; m_ldata = 0;
    end else begin
      bit rise, n_err;
      rise  = host_wr_en && host_wdata[24] && !m_req;
      n_err = m_err;
      if (host_wr_en && host_wdata[31]) n_err = 0;
      if (rise && m_ack) n_err = 1;
      case (m_phase)
        0: if (rise) begin m_phase = 1; m_laddr = host_wdata[5:0]; m_ldata = host_wdata[15:8]; end
        1: m_phase = 2;
        2: if (phy_ready) m_phase = 3;
        3: if (!m_req) m_phase = 4;
        default: m_phase = 0;
      endcase
      m_ack = (m_phase == 3) || (m_phase == 4);
      if (host_wr_en) begin
        m_addr = host_wdata[5:0];
        m_data = host_wdata[15:8];
        m_req  = host_wdata[24];
      end
      m_err = n_err;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [31:0] exp_w;
      exp_w = mk(m_err, m_ack, m_req, m_data, m_addr);
      check(host_rdata == exp_w, "R1/R4/R5/R7/R8 word", host_rdata, exp_w);
      check(phy_wr_stb == (m_phase == 1), "R2 strobe", {31'b0, phy_wr_stb}, {31'b0, m_phase == 1});
      if (phy_wr_stb)
        check({phy_addr, phy_wdata} == {m_laddr, m_ldata}, "R2/R6 phy bus",
              {18'b0, phy_addr, phy_wdata}, {18'b0, m_laddr, m_ldata});
    end
  end

  // Host-side helpers, always entered and left at a falling edge
  task automatic host_write(input logic [31:0] w);
    host_wr_en = 1'b1;
    host_wdata = w;
    @(negedge clk);
    host_wr_en = 1'b0;
    host_wdata = '0;
  endtask

  task automatic wait_ack(input bit val, output int cycles);
    cycles = 0;
    while (host_rdata[26] != val && cycles < 40) begin
      @(negedge clk);
      cycles++;
    end
    check(host_rdata[26] == val, "R4/R5 ack wait", {31'b0, host_rdata[26]}, {31'b0, val});
  endtask

  task automatic write_phy(input logic [5:0] a, input logic [7:0] d, input int lat);
    int n;
    phy_lat = lat;
    host_write(mk(0, 0, 1, d, a));
    wait_ack(1, n);
    check(n == lat + 1, "R4 ack latency", n, lat + 1);
    host_write(mk(0, 0, 0, d, a));
    check(host_rdata[26] == 1'b1, "R5 ack held one", {31'b0, host_rdata[26]}, 1);
    @(negedge clk);
    check(host_rdata[26] == 1'b1, "R5 ack held two", {31'b0, host_rdata[26]}, 1);
    @(negedge clk);
    check(host_rdata[26] == 1'b0, "R5 ack released", {31'b0, host_rdata[26]}, 0);
    check(phy_mem[a] == d, "R2 phy register", {24'b0, phy_mem[a]}, {24'b0, d});
  endtask

  initial begin
    int n;
    rst_n = 1'b0;
    host_wr_en = 1'b0;
    host_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset contents
    check(host_rdata == 32'h0, "R10 reset word", host_rdata, 0);
    check(phy_wr_stb == 1'b0, "R10 reset strobe", {31'b0, phy_wr_stb}, 0);

    // R1, R9: spare bits and acknowledge ignore writes
    host_write(32'h7EFF_FFFF);
    check(host_rdata == 32'h0000_FF3F, "R1 spare bits / R9 ack write", host_rdata, 32'h0000_FF3F);
    host_write(32'h0000_0000);

    // R3: stray ready while idle
    spur = 1;
    repeat (3) @(negedge clk);
    spur = 0;
    @(negedge clk);
    check(host_rdata[26] == 1'b0, "R3 stray ready", {31'b0, host_rdata[26]}, 0);

    // R2, R4, R5: each latency 1..8 and the index limits
    for (int l = 1; l <= 8; l++) write_phy(6'(l * 7), 8'(8'h30 + l), l);
    write_phy(6'd0, 8'hC3, 3);
    write_phy(6'd63, 8'h5A, 5);

    // R6: field changes during a transfer
    phy_lat = 8;
    host_write(mk(0, 0, 1, 8'h11, 6'd10));
    host_write(mk(0, 0, 1, 8'h99, 6'd20));
    wait_ack(1, n);
    host_write(mk(0, 0, 0, 8'h99, 6'd20));
    wait_ack(0, n);
    check(phy_mem[10] == 8'h11, "R6 latched data", {24'b0, phy_mem[10]}, 32'h11);
    check(phy_mem[20] == 8'h00, "R6 untouched index", {24'b0, phy_mem[20]}, 0);

    // R7: request raised again while acknowledge is high
    phy_lat = 2;
    host_write(mk(0, 0, 1, 8'h5A, 6'd1));
    wait_ack(1, n);
    host_write(mk(0, 0, 0, 8'h5A, 6'd1));
    host_write(mk(0, 0, 1, 8'hE7, 6'd2));
    check(host_rdata[31] == 1'b1, "R7 error set", {31'b0, host_rdata[31]}, 1);
    repeat (6) @(negedge clk);
    check(phy_mem[2] == 8'h00, "R7 no transfer", {24'b0, phy_mem[2]}, 0);
    check(host_rdata[26] == 1'b0, "R7 ack idle", {31'b0, host_rdata[26]}, 0);

    // R8: clear, then set and clear in the same write
    host_write(mk(1, 0, 1, 8'hE7, 6'd2));
    check(host_rdata[31] == 1'b0, "R8 error cleared", {31'b0, host_rdata[31]}, 0);
    host_write(mk(0, 0, 0, 8'h00, 6'd3));
    host_write(mk(0, 0, 1, 8'h42, 6'd3));
    wait_ack(1, n);
    host_write(mk(0, 0, 0, 8'h42, 6'd3));
    host_write(mk(1, 0, 1, 8'h77, 6'd4));
    check(host_rdata[31] == 1'b1, "R8 set wins", {31'b0, host_rdata[31]}, 1);
    host_write(mk(1, 0, 0, 8'h00, 6'd0));
    wait_ack(0, n);
    check(host_rdata[31] == 1'b0, "R8 final clear", {31'b0, host_rdata[31]}, 0);
    check(phy_mem[4] == 8'h00, "R7 no transfer after collision", {24'b0, phy_mem[4]}, 0);

    // R10: reset in the middle of a transfer
    phy_lat = 8;
    host_write(mk(0, 0, 1, 8'hAB, 6'd30));
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(host_rdata == 32'h0, "R10 mid-transfer word", host_rdata, 0);
    check(phy_wr_stb == 1'b0, "R10 mid-transfer strobe", {31'b0, phy_wr_stb}, 0);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    check(host_rdata == 32'h0, "R10 word after release", host_rdata, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule